// File: doc/BRIEF.md
# Endpoint Test Function Controller

This block is the register-mapped test function of a bus endpoint. A host reaches it through a plain 32-bit register port. It can store a scratch pattern, and it can run one command at a time. A command either raises an interrupt request of a chosen kind, or moves 32-bit words between buffers in host memory. Moves use a word-wide memory master port with a valid/ready handshake. After each command the block reports the outcome in a status word.

Raise commands take the interrupt kind from the command bit and the number from the interrupt-number register. A transfer command signals its completion with the interrupt kind held in the interrupt-type register. Before any interrupt goes out, its number is checked against the range allowed for its kind. A bad source or destination address stops a transfer before any memory access, and the block reports which address was at fault.

Top module: `ep_test_ctrl`

Register offsets (byte address on `host_addr`): 0x00 pattern, 0x04 command, 0x08 status (read-only), 0x0C source address, 0x10 destination address, 0x14 transfer size in bytes, 0x18 checksum (read-only), 0x1C interrupt type, 0x20 interrupt number. Unmapped offsets read as zero.

## Requirements
- R1: The pattern register at 0x00 returns exactly the last value written to it. The source, destination, size, type and number registers also read back what was written.
- R2: A write to the command register starts an operation only when the block is idle and exactly one of bits 0..5 is set. A write of zero, a write with several bits set, or a write during a running operation changes neither the command nor the status.
- R3: Command bit 0, bit 1 and bit 2 raise an interrupt of type 0 (legacy), 1 (MSI) or 2 (MSI-X) respectively, with the number taken from the number register. Status bit 6 is then set.
- R4: An interrupt goes out only if its number is 0 for type 0, 1..32 for type 1, or 1..2048 for type 2. Otherwise no pulse is sent and status bit 6 stays clear.
- R5: Command bit 3 reads size/4 words upward from the source address. On success it sets status bit 0, and the checksum holds the XOR of the words read.
- R6: Command bit 4 writes size/4 words upward from the destination address. Word i carries the pattern register value plus i. On success it sets status bit 2, and the checksum holds the XOR of the words written.
- R7: Command bit 5 copies size/4 words from the source buffer to the destination buffer. On success it sets status bit 4, and the checksum holds the XOR of the words copied.
- R8: An address is invalid if it is zero or not a multiple of 4. A read or copy with an invalid source sets status bit 7. A write or copy with an invalid destination sets status bit 8. Either case sets the command's fail bit (bit 1 read, bit 3 write, bit 5 copy) and makes no memory request.
- R9: Status bits 0..8 are all cleared when a new command starts.
- R10: A read, write or copy completion, successful or failed, is signalled by a one-cycle interrupt pulse. The pulse carries the type and number registers, subject to R4.
- R11: The command register reads the running command while the operation is in progress, and reads zero once it finishes.
- R12: While a memory request waits for ready, the request, direction, address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 6 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_type | output | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 12 | Interrupt number |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 12-bit interrupt number, an MSI limit of 32 and an MSI-X limit of 2048. With a 12-bit number field, the value just above each limit (33 and 2049) can be stored, so the bench can probe both edges of every range. The memory model can stall ready in a fixed pattern. This exercises request holding during a multi-word copy and the rejection of commands written while the copy runs.

// File: rtl/ep_test_pkg.sv
package ep_test_pkg;

  localparam int HOST_AW = 6;
  localparam int CMD_W   = 6;
  localparam int STS_W   = 9;

  // register byte offsets
  localparam logic [HOST_AW-1:0] OFF_PATTERN = 6'h00;
  localparam logic [HOST_AW-1:0] OFF_CMD     = 6'h04;
  localparam logic [HOST_AW-1:0] OFF_STATUS  = 6'h08;
  localparam logic [HOST_AW-1:0] OFF_SRC     = 6'h0C;
  localparam logic [HOST_AW-1:0] OFF_DST     = 6'h10;
  localparam logic [HOST_AW-1:0] OFF_SIZE    = 6'h14;
  localparam logic [HOST_AW-1:0] OFF_CSUM    = 6'h18;
  localparam logic [HOST_AW-1:0] OFF_ITYPE   = 6'h1C;
  localparam logic [HOST_AW-1:0] OFF_INUM    = 6'h20;

  // command bit positions
  localparam int CMD_LEG  = 0;
  localparam int CMD_MSI  = 1;
  localparam int CMD_MSIX = 2;
  localparam int CMD_RD   = 3;
  localparam int CMD_WR   = 4;
  localparam int CMD_CP   = 5;

  // status bit positions
  localparam int STS_RD_OK   = 0;
  localparam int STS_RD_FAIL = 1;
  localparam int STS_WR_OK   = 2;
  localparam int STS_WR_FAIL = 3;
  localparam int STS_CP_OK   = 4;
  localparam int STS_CP_FAIL = 5;
  localparam int STS_IRQ     = 6;
  localparam int STS_SRC_BAD = 7;
  localparam int STS_DST_BAD = 8;

  localparam logic [1:0] IRQ_LEGACY = 2'd0;
  localparam logic [1:0] IRQ_MSI    = 2'd1;
  localparam logic [1:0] IRQ_MSIX   = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RD,
    S_WR,
    S_IRQ
  } seq_state_e;

endpackage

// File: rtl/ep_test_regs.sv
module ep_test_regs
  import ep_test_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr_i,
  input  logic [HOST_AW-1:0]   host_addr_i,
  input  logic [DATA_W-1:0]    host_wdata_i,
  output logic [DATA_W-1:0]    host_rdata_o,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [STS_W-1:0]     status_i,
  input  logic [DATA_W-1:0]    csum_i,
  output logic                 cmd_wr_o,
  output logic [DATA_W-1:0]    pattern_o,
  output logic [DATA_W-1:0]    src_o,
  output logic [DATA_W-1:0]    dst_o,
  output logic [DATA_W-1:0]    size_o,
  output logic [1:0]           itype_o,
  output logic [NUM_W-1:0]     inum_o
);

  logic we_pat, we_src, we_dst, we_size, we_type, we_num;

  logic [DATA_W-1:0] pat_q, src_q, dst_q, size_q;
  logic [1:0]        type_q;
  logic [NUM_W-1:0]  num_q;

  // write decode
  always_comb begin
    we_pat   = host_wr_i && (host_addr_i == OFF_PATTERN);
    we_src   = host_wr_i && (host_addr_i == OFF_SRC);
    we_dst   = host_wr_i && (host_addr_i == OFF_DST);
    we_size  = host_wr_i && (host_addr_i == OFF_SIZE);
    we_type  = host_wr_i && (host_addr_i == OFF_ITYPE);
    we_num   = host_wr_i && (host_addr_i == OFF_INUM);
    cmd_wr_o = host_wr_i && (host_addr_i == OFF_CMD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (we_pat) begin
      pat_q <= host_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (we_src) begin
      src_q <= host_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (we_dst) begin
      dst_q <= host_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
    end else if (we_size) begin
      size_q <= host_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
    end else if (we_type) begin
      type_q <= host_wdata_i[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
    end else if (we_num) begin
      num_q <= host_wdata_i[NUM_W-1:0];
    end
  end

  // read mux
  always_comb begin
    host_rdata_o = '0;
    case (host_addr_i)
      OFF_PATTERN: host_rdata_o = pat_q;
      OFF_CMD:     host_rdata_o = DATA_W'(cmd_i);
      OFF_STATUS:  host_rdata_o = DATA_W'(status_i);
      OFF_SRC:     host_rdata_o = src_q;
      OFF_DST:     host_rdata_o = dst_q;
      OFF_SIZE:    host_rdata_o = size_q;
      OFF_CSUM:    host_rdata_o = csum_i;
      OFF_ITYPE:   host_rdata_o = DATA_W'(type_q);
      OFF_INUM:    host_rdata_o = DATA_W'(num_q);
      default:     host_rdata_o = '0;
    endcase
  end

  assign pattern_o = pat_q;
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign size_o    = size_q;
  assign itype_o   = type_q;
  assign inum_o    = num_q;

endmodule

// File: rtl/ep_test_irq.sv
module ep_test_irq
  import ep_test_pkg::*;
#(
  parameter int NUM_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic             fire_i,
  input  logic [1:0]       type_i,
  input  logic [NUM_W-1:0] num_i,
  output logic             raised_o,
  output logic             irq_pulse_o,
  output logic [1:0]       irq_type_o,
  output logic [NUM_W-1:0] irq_num_o
);

  localparam logic [NUM_W-1:0] MSI_LIM  = NUM_W'(MSI_MAX);
  localparam logic [NUM_W-1:0] MSIX_LIM = NUM_W'(MSIX_MAX);

  logic legal;

  always_comb begin
    case (type_i)
      IRQ_LEGACY: legal = (num_i == '0);
      IRQ_MSI:    legal = (num_i != '0) && (num_i <= MSI_LIM);
      IRQ_MSIX:   legal = (num_i != '0) && (num_i <= MSIX_LIM);
      default:    legal = 1'b0;
    endcase
  end

  assign raised_o    = fire_i && legal;
  assign irq_pulse_o = raised_o;
  assign irq_type_o  = type_i;
  assign irq_num_o   = num_i;

endmodule

// File: rtl/ep_test_seq.sv
module ep_test_seq
  import ep_test_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] size_i,
  input  logic [1:0]        itype_i,
  input  logic              irq_raised_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [STS_W-1:0]  status_o,
  output logic [DATA_W-1:0] csum_o,
  output logic              irq_fire_o,
  output logic [1:0]        irq_type_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);

  localparam int CNT_W = DATA_W - 2;

  seq_state_e        state_q, state_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [STS_W-1:0]  status_q, status_d;
  logic [DATA_W-1:0] csum_q, csum_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;

  logic              is_irq, is_rd, is_wr, is_cp;
  logic              cmd_start, src_bad, dst_bad, last;
  logic [CNT_W-1:0]  words;
  logic [DATA_W-1:0] offs, wdata_sel;
  logic [STS_W-1:0]  ok_mask, fail_mask;
  logic              unused_size;

  function automatic logic addr_bad(input logic [DATA_W-1:0] a);
    return (a == '0) || (a[1:0] != 2'b00);
  endfunction

  assign unused_size = ^size_i[1:0];

  always_comb begin
    is_irq    = cmd_q[CMD_LEG] | cmd_q[CMD_MSI] | cmd_q[CMD_MSIX];
    is_rd     = cmd_q[CMD_RD];
    is_wr     = cmd_q[CMD_WR];
    is_cp     = cmd_q[CMD_CP];
    cmd_start = cmd_wr_i && (cmd_wdata_i != '0) &&
                ((cmd_wdata_i & (cmd_wdata_i - 1'b1)) == '0);
    src_bad   = (is_rd || is_cp) && addr_bad(src_i);
    dst_bad   = (is_wr || is_cp) && addr_bad(dst_i);
    words     = size_i[DATA_W-1:2];
    last      = (idx_q == words - CNT_W'(1));
    offs      = {idx_q, 2'b00};
    wdata_sel = is_cp ? hold_q : (pattern_i + {2'b00, idx_q});

    ok_mask                = '0;
    ok_mask[STS_RD_OK]     = is_rd;
    ok_mask[STS_WR_OK]     = is_wr;
    ok_mask[STS_CP_OK]     = is_cp;
    fail_mask              = '0;
    fail_mask[STS_RD_FAIL] = is_rd;
    fail_mask[STS_WR_FAIL] = is_wr;
    fail_mask[STS_CP_FAIL] = is_cp;

    if (cmd_q[CMD_LEG])       irq_type_o = IRQ_LEGACY;
    else if (cmd_q[CMD_MSI])  irq_type_o = IRQ_MSI;
    else if (cmd_q[CMD_MSIX]) irq_type_o = IRQ_MSIX;
    else                      irq_type_o = itype_i;
  end

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cmd_d       = cmd_q;
    status_d    = status_q;
    csum_d      = csum_q;
    idx_d       = idx_q;
    hold_d      = hold_q;
    hold_en     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    irq_fire_o  = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (cmd_start) begin
          cmd_d    = cmd_wdata_i;
          status_d = '0;
          idx_d    = '0;
          if (cmd_wdata_i[CMD_RD] | cmd_wdata_i[CMD_WR] | cmd_wdata_i[CMD_CP]) begin
            csum_d = '0;
          end
          state_d = S_CHECK;
        end
      end

      S_CHECK: begin
        if (is_irq) begin
          state_d = S_IRQ;
        end else if (src_bad || dst_bad) begin
          status_d[STS_SRC_BAD] = src_bad;
          status_d[STS_DST_BAD] = dst_bad;
          status_d              = status_d | fail_mask;
          state_d               = S_IRQ;
        end else if (words == '0) begin
          status_d = status_d | ok_mask;
          state_d  = S_IRQ;
        end else if (is_wr) begin
          state_d = S_WR;
        end else begin
          state_d = S_RD;
        end
      end

      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_i + offs;
        if (mem_ready_i) begin
          if (is_cp) begin
            hold_d  = mem_rdata_i;
            hold_en = 1'b1;
            state_d = S_WR;
          end else begin
            csum_d = csum_q ^ mem_rdata_i;
            if (last) begin
              status_d = status_d | ok_mask;
              state_d  = S_IRQ;
            end else begin
              idx_d = idx_q + CNT_W'(1);
            end
          end
        end
      end

      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_i + offs;
        mem_wdata_o = wdata_sel;
        if (mem_ready_i) begin
          csum_d = csum_q ^ wdata_sel;
          if (last) begin
            status_d = status_d | ok_mask;
            state_d  = S_IRQ;
          end else begin
            idx_d   = idx_q + CNT_W'(1);
            state_d = is_cp ? S_RD : S_WR;
          end
        end
      end

      S_IRQ: begin
        irq_fire_o = 1'b1;
        if (irq_raised_i) begin
          status_d[STS_IRQ] = 1'b1;
        end
        cmd_d   = '0;
        state_d = S_IDLE;
      end

      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cmd_q    <= '0;
      status_q <= '0;
      csum_q   <= '0;
      idx_q    <= '0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      status_q <= status_d;
      csum_q   <= csum_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign cmd_o    = cmd_q;
  assign status_o = status_q;
  assign csum_o   = csum_q;

endmodule

// File: rtl/ep_test_ctrl.sv
module ep_test_ctrl
  import ep_test_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              irq_pulse,
  output logic [1:0]        irq_type,
  output logic [NUM_W-1:0]  irq_num
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  logic              cmd_wr_w;
  logic [CMD_W-1:0]  cmd_w;
  logic [STS_W-1:0]  status_w;
  logic [DATA_W-1:0] csum_w, pattern_w, src_w, dst_w, size_w;
  logic [1:0]        itype_w, fire_type_w;
  logic [NUM_W-1:0]  inum_w;
  logic              fire_w, raised_w;

  ep_test_regs #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sn),
    .host_wr_i    (host_wr),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata),
    .cmd_i        (cmd_w),
    .status_i     (status_w),
    .csum_i       (csum_w),
    .cmd_wr_o     (cmd_wr_w),
    .pattern_o    (pattern_w),
    .src_o        (src_w),
    .dst_o        (dst_w),
    .size_o       (size_w),
    .itype_o      (itype_w),
    .inum_o       (inum_w)
  );

  ep_test_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sn),
    .cmd_wr_i     (cmd_wr_w),
    .cmd_wdata_i  (host_wdata[CMD_W-1:0]),
    .pattern_i    (pattern_w),
    .src_i        (src_w),
    .dst_i        (dst_w),
    .size_i       (size_w),
    .itype_i      (itype_w),
    .irq_raised_i (raised_w),
    .cmd_o        (cmd_w),
    .status_o     (status_w),
    .csum_o       (csum_w),
    .irq_fire_o   (fire_w),
    .irq_type_o   (fire_type_w),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .mem_ready_i  (mem_ready)
  );

  ep_test_irq #(.NUM_W(NUM_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_irq (
    .fire_i      (fire_w),
    .type_i      (fire_type_w),
    .num_i       (inum_w),
    .raised_o    (raised_w),
    .irq_pulse_o (irq_pulse),
    .irq_type_o  (irq_type),
    .irq_num_o   (irq_num)
  );

endmodule

// File: rtl/ep_test_chk.sv
module ep_test_chk
  import ep_test_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              irq_pulse,
  input logic [STS_W-1:0]  status_w,
  input logic [CMD_W-1:0]  cmd_w,
  input logic [DATA_W-1:0] src_w,
  input logic [DATA_W-1:0] dst_w
);

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_pulse |=> !irq_pulse);

  p_pulse_status_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_pulse |=> status_w[STS_IRQ]);

  p_busy_cmd_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> (cmd_w != '0));

  p_src_valid_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_we) |-> ((src_w != '0) && (src_w[1:0] == 2'b00)));

  p_dst_valid_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && mem_we) |-> ((dst_w != '0) && (dst_w[1:0] == 2'b00)));

endmodule

bind ep_test_ctrl ep_test_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq_pulse (irq_pulse),
  .status_w  (status_w),
  .cmd_w     (cmd_w),
  .src_w     (src_w),
  .dst_w     (dst_w)
);

// File: tb/tb_ep_test_ctrl.sv
module tb_ep_test_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_pulse;
  logic [1:0]  irq_type;
  logic [11:0] irq_num;

  int pass_cnt = 0;
  int total_cnt = 0;
  int irq_cnt = 0;
  int acc_cnt = 0;
  logic [1:0]  last_type;
  logic [11:0] last_num;
  logic        stall_en;
  logic [7:0]  rdy_cnt;
  logic [31:0] mem [0:63];

  ep_test_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq_pulse(irq_pulse),
    .irq_type(irq_type), .irq_num(irq_num)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 + i * 32'h0001_0003;
  endfunction

  // memory model
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      acc_cnt <= 0;
    end else if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n && irq_pulse) begin
      irq_cnt   <= irq_cnt + 1;
      last_type <= irq_type;
      last_num  <= irq_num;
    end
  end

  always @(negedge clk) begin
    rdy_cnt   <= rdy_cnt + 8'd1;
    mem_ready <= !stall_en || (rdy_cnt[1:0] != 2'b00);
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] c;
    int n = 0;
    c = 32'hFFFF_FFFF;
    while (c != 0 && n < 2000) begin
      reg_rd(6'h04, c);
      n++;
    end
    check(c == 0, tag, c, 0);
  endtask

  task automatic run_cmd(input logic [31:0] cmd, input string tag);
    reg_wr(6'h04, cmd);
    wait_done(tag);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(6'h08, v); check(v == 0, "reset status", v, 0);
    reg_rd(6'h04, v); check(v == 0, "reset cmd R11", v, 0);
    check(irq_pulse == 0 && mem_req == 0, "reset outputs", {30'd0, irq_pulse, mem_req}, 0);
  endtask

  task automatic t_regs_r1();
    logic [31:0] v;
    reg_wr(6'h00, 32'hA5C3_0F96); reg_rd(6'h00, v);
    check(v == 32'hA5C3_0F96, "R1 pattern", v, 32'hA5C3_0F96);
    reg_wr(6'h00, 32'h0123_4567); reg_rd(6'h00, v);
    check(v == 32'h0123_4567, "R1 pattern 2", v, 32'h0123_4567);
    reg_wr(6'h0C, 32'h0000_0020); reg_rd(6'h0C, v);
    check(v == 32'h20, "R1 src", v, 32'h20);
    reg_wr(6'h20, 32'd2048); reg_rd(6'h20, v);
    check(v == 32'd2048, "R1 num", v, 32'd2048);
  endtask

  task automatic t_raise_r3();
    logic [31:0] v;
    int c0;
    reg_wr(6'h20, 0); c0 = irq_cnt;
    run_cmd(32'h01, "R3 legacy done");
    check(irq_cnt == c0 + 1 && last_type == 0 && last_num == 0, "R3 legacy irq",
          {last_type, 18'd0, last_num}, 0);
    reg_rd(6'h08, v); check(v == 32'h40, "R3 legacy status", v, 32'h40);
    reg_wr(6'h20, 32); c0 = irq_cnt;
    run_cmd(32'h02, "R3 msi done");
    check(irq_cnt == c0 + 1 && last_type == 1 && last_num == 32, "R3 msi irq max",
          {last_type, 18'd0, last_num}, {2'd1, 18'd0, 12'd32});
    reg_wr(6'h20, 2048); c0 = irq_cnt;
    run_cmd(32'h04, "R3 msix done");
    check(irq_cnt == c0 + 1 && last_type == 2 && last_num == 2048, "R3 msix irq max",
          {last_type, 18'd0, last_num}, {2'd2, 18'd0, 12'd2048});
    reg_rd(6'h08, v); check(v == 32'h40, "R3 msix status", v, 32'h40);
  endtask

  task automatic t_range_r4();
    logic [31:0] v;
    int c0;
    c0 = irq_cnt;
    reg_wr(6'h20, 33);   run_cmd(32'h02, "R4 msi33 done");
    reg_rd(6'h08, v); check(v == 0, "R4 msi 33 status", v, 0);
    reg_wr(6'h20, 5);    run_cmd(32'h01, "R4 legacy5 done");
    reg_wr(6'h20, 0);    run_cmd(32'h04, "R4 msix0 done");
    reg_rd(6'h08, v); check(v == 0, "R4 msix 0 status", v, 0);
    reg_wr(6'h20, 2049); run_cmd(32'h04, "R4 msix2049 done");
    check(irq_cnt == c0, "R4 no pulses", irq_cnt, c0);
  endtask

  task automatic t_read_r5();
    logic [31:0] v, exp;
    int c0, a0;
    exp = pat(8) ^ pat(9) ^ pat(10) ^ pat(11);
    reg_wr(6'h0C, 32'h20); reg_wr(6'h14, 16);
    reg_wr(6'h1C, 1); reg_wr(6'h20, 3);
    c0 = irq_cnt; a0 = acc_cnt;
    run_cmd(32'h08, "R5 read done");
    reg_rd(6'h08, v); check(v == 32'h41, "R5 read status", v, 32'h41);
    reg_rd(6'h18, v); check(v == exp, "R5 checksum", v, exp);
    check(acc_cnt == a0 + 4, "R5 word count", acc_cnt, a0 + 4);
    check(irq_cnt == c0 + 1 && last_type == 1 && last_num == 3, "R10 read completion irq",
          {last_type, 18'd0, last_num}, {2'd1, 18'd0, 12'd3});
  endtask

  task automatic t_write_r6();
    logic [31:0] v, m;
    m = 32'h1000_0000;
    reg_wr(6'h00, m); reg_wr(6'h10, 32'h40); reg_wr(6'h14, 12);
    reg_wr(6'h1C, 0); reg_wr(6'h20, 0);
    run_cmd(32'h10, "R6 write done");
    reg_rd(6'h08, v); check(v == 32'h44, "R6 write status", v, 32'h44);
    for (int i = 0; i < 3; i++)
      check(mem[16+i] == m + i, "R6 written word", mem[16+i], m + i);
    check(mem[19] == pat(19), "R6 no overrun", mem[19], pat(19));
    reg_rd(6'h18, v);
    check(v == (m ^ (m + 1) ^ (m + 2)), "R6 checksum", v, m ^ (m + 1) ^ (m + 2));
  endtask

  task automatic t_copy_r7();
    logic [31:0] v, exp;
    int c0;
    exp = pat(8) ^ pat(9) ^ pat(10) ^ pat(11);
    stall_en = 1'b1;
    reg_wr(6'h0C, 32'h20); reg_wr(6'h10, 32'h80); reg_wr(6'h14, 16);
    reg_wr(6'h1C, 2); reg_wr(6'h20, 7);
    c0 = irq_cnt;
    reg_wr(6'h04, 32'h20);
    reg_rd(6'h04, v); check(v == 32'h20, "R11 cmd while busy", v, 32'h20);
    reg_wr(6'h04, 32'h01);
    reg_rd(6'h04, v); check(v == 32'h20, "R2 busy write ignored", v, 32'h20);
    wait_done("R7 copy done");
    stall_en = 1'b0;
    for (int i = 0; i < 4; i++)
      check(mem[32+i] == pat(8+i), "R7 copied word R12", mem[32+i], pat(8+i));
    reg_rd(6'h08, v); check(v == 32'h50, "R7 copy status", v, 32'h50);
    reg_rd(6'h18, v); check(v == exp, "R7 checksum", v, exp);
    check(irq_cnt == c0 + 1 && last_type == 2 && last_num == 7, "R10 copy irq only once",
          irq_cnt, c0 + 1);
  endtask

  task automatic t_bad_r8();
    logic [31:0] v;
    int a0;
    reg_wr(6'h1C, 0); reg_wr(6'h20, 0); reg_wr(6'h14, 8);
    a0 = acc_cnt;
    reg_wr(6'h0C, 32'h22); run_cmd(32'h08, "R8 read done");
    reg_rd(6'h08, v); check(v == 32'hC2, "R8 misaligned src", v, 32'hC2);
    reg_wr(6'h10, 32'h0); run_cmd(32'h10, "R8 write done");
    reg_rd(6'h08, v); check(v == 32'h148, "R8 zero dst", v, 32'h148);
    reg_wr(6'h0C, 32'h20); reg_wr(6'h10, 32'h81); run_cmd(32'h20, "R8 copy done");
    reg_rd(6'h08, v); check(v == 32'h160, "R8 misaligned dst copy", v, 32'h160);
    check(acc_cnt == a0, "R8 no memory access", acc_cnt, a0);
  endtask

  task automatic t_ignore_r2();
    logic [31:0] v;
    int c0;
    c0 = irq_cnt;
    reg_wr(6'h04, 32'h00); repeat (4) @(negedge clk);
    reg_rd(6'h04, v); check(v == 0, "R2 zero cmd", v, 0);
    reg_wr(6'h04, 32'h03); repeat (4) @(negedge clk);
    reg_rd(6'h04, v); check(v == 0, "R2 multi-bit cmd", v, 0);
    reg_rd(6'h08, v); check(v == 32'h160, "R2 status untouched", v, 32'h160);
    check(irq_cnt == c0, "R2 no irq", irq_cnt, c0);
  endtask

  task automatic t_clear_r9();
    logic [31:0] v;
    reg_wr(6'h20, 0);
    run_cmd(32'h01, "R9 done");
    reg_rd(6'h08, v); check(v == 32'h40, "R9 status cleared", v, 32'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    stall_en = 1'b0; rdy_cnt = '0; mem_ready = 1'b1;
    last_type = '0; last_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs_r1();
    t_raise_r3();
    t_range_r4();
    t_read_r5();
    t_write_r6();
    t_copy_r7();
    t_bad_r8();
    t_ignore_r2();
    t_clear_r9();
    $display("%0d/%0d checks passed", pass_cnt, total_cnt);
    $finish;
  end

endmodule